// File: doc/BRIEF.md
# Chainable Twin Counter with Freeze-on-Read Capture

Two W-bit counters, Timer 0 and Timer 1, run on one clock. Each counter has its own 3-bit mode, its own compare value and its own capture register. A compare-match flag and a waveform output follow from each counter, and the waveform can be a toggling square wave or a PWM level. A cascade input joins the counters into one 2W-bit counter. In that case Timer 1 counts the wraps of Timer 0, and Timer 0's compare logic looks at the joined value.

In counting and waveform modes, the capture register acts as a read shadow. A one-cycle read strobe copies the live count into it, and that value stays frozen until the next strobe. Timer 0 has two more modes that measure an external gate signal. The gate passes through a two-flop synchroniser. Its edges restart the counter and latch a length measured in clock cycles, either the period between rising edges or the time the gate stays high.

Mode codes are 0 halt, 1 count, 2 frequency, 3 PWM, 4 period measurement and 5 high-time measurement. Codes 6 and 7 act as halt. Timer 1 treats codes 4 and 5 as halt.

Top module: `dt_timer`

## Requirements
- R1: While `rst` is high and in the cycle after it drops, both counts, both captures, both match flags and both waves are 0.
- R2: In mode 0, Timer 0's count keeps its value from cycle to cycle.
- R3: In mode 1 without cascade, each counter adds 1 per clock and wraps from all-ones to 0.
- R4: With `cascade` high, the 2W-bit value {t1_count,t0_count} adds 1 per clock. Timer 1 changes only on the clock where Timer 0 wraps, and `t1_match` and `t1_wave` stay 0 whatever Timer 1's mode is.
- R5: A running timer's match flag is 1 in the cycle right after its count equalled its compare value. In cascade, Timer 0 compares {t1_count,t0_count} with {t1_cmp,t0_cmp}.
- R6: In mode 2 the counter steps 0..cmp and then returns to 0, and the wave inverts at each return. With cmp = C, after i clocks the count is i mod (C+1) and the wave is bit 0 of floor(i/(C+1)).
- R7: In mode 3 the counter wraps freely, and the wave in a cycle is 1 exactly when the count of the previous cycle was below the compare value.
- R8: Outside modes 4 and 5, a one-cycle read strobe loads the count of that cycle into the capture register, and the value holds afterwards. In cascade, either strobe loads both registers with the 2W-bit count, upper half in `t1_cap`.
- R9: In modes 4 and 5 of Timer 0, the read strobes leave the capture registers unchanged.
- R10: In mode 4, each synchronised rising gate edge restarts the count and captures the number of clocks since the previous rising edge. In cascade the capture spans both registers.
- R11: In mode 5, a synchronised rising gate edge restarts the count, and the falling edge captures the gate's high time in clocks.
- R12: Timer 1 in mode 4 or 5 keeps its count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cascade | input | 1 | Join the counters into one 2W-bit counter |
| t0_mode | input | 3 | Timer 0 mode code |
| t1_mode | input | 3 | Timer 1 mode code |
| t0_cmp | input | W | Timer 0 compare value |
| t1_cmp | input | W | Timer 1 compare value |
| t0_rd | input | 1 | Timer 0 read strobe |
| t1_rd | input | 1 | Timer 1 read strobe |
| gate_in | input | 1 | External gate for measurement (asynchronous) |
| t0_count | output | W | Timer 0 count |
| t1_count | output | W | Timer 1 count |
| t0_cap | output | W | Timer 0 capture register |
| t1_cap | output | W | Timer 1 capture register |
| t0_match | output | 1 | Timer 0 compare-match flag |
| t1_match | output | 1 | Timer 1 compare-match flag |
| t0_wave | output | 1 | Timer 0 waveform |
| t1_wave | output | 1 | Timer 1 waveform |

## Verification
The joined counter is the hardest state to reach. Its carry into Timer 1 and its wide compare only act after hundreds of clocks, so the stimulus runs the cascade for 700 cycles. During that run it checks the 2W-bit count every cycle, looks for the single match at 300, and then freezes the value with a read. The gate measurements are hidden behind three register stages. The stimulus sweeps several periods and high times, including a one-cycle pulse and a 700-cycle cascaded period, and then reads back the exact cycle counts.

// File: rtl/dt_pkg.sv
package dt_pkg;
  typedef enum logic [2:0] {
    MD_STOP   = 3'd0,
    MD_COUNT  = 3'd1,
    MD_FREQ   = 3'd2,
    MD_PWM    = 3'd3,
    MD_PERIOD = 3'd4,
    MD_PULSE  = 3'd5
  } mode_e;
endpackage

// File: rtl/dt_sync.sv
module dt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-1:0], din};
  end

  assign rise = sh[STAGES-1] & ~sh[STAGES];
  assign fall = ~sh[STAGES-1] & sh[STAGES];
endmodule

// File: rtl/dt_slice.sv
module dt_slice #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic         clr,
  input  logic         cap_ld,
  input  logic [W-1:0] cap_val,
  output logic [W-1:0] cnt,
  output logic [W-1:0] cap
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      cap <= '0;
    end else begin
      if (clr)      cnt <= '0;
      else if (inc) cnt <= cnt + 1'b1;
      if (cap_ld)   cap <= cap_val;
    end
  end
endmodule

// File: rtl/dt_wave.sv
module dt_wave
  import dt_pkg::*;
#(
  parameter int VW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [2:0]    mode,
  input  logic [VW-1:0] val,
  input  logic [VW-1:0] cmp,
  output logic          hit,
  output logic          match_q,
  output logic          wave_q
);
  assign hit = en && (val == cmp);

  always_ff @(posedge clk) begin
    if (rst) begin
      match_q <= 1'b0;
      wave_q  <= 1'b0;
    end else begin
      match_q <= hit;
      if (!en)                 wave_q <= 1'b0;
      else if (mode == MD_FREQ) begin
        if (hit) wave_q <= ~wave_q;
      end
      else if (mode == MD_PWM) wave_q <= (val < cmp);
      else                     wave_q <= 1'b0;
    end
  end
endmodule

// File: rtl/dt_timer.sv
module dt_timer
  import dt_pkg::*;
#(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cascade,
  input  logic [2:0]   t0_mode,
  input  logic [2:0]   t1_mode,
  input  logic [W-1:0] t0_cmp,
  input  logic [W-1:0] t1_cmp,
  input  logic         t0_rd,
  input  logic         t1_rd,
  input  logic         gate_in,
  output logic [W-1:0] t0_count,
  output logic [W-1:0] t1_count,
  output logic [W-1:0] t0_cap,
  output logic [W-1:0] t1_cap,
  output logic         t0_match,
  output logic         t1_match,
  output logic         t0_wave,
  output logic         t1_wave
);
  localparam int          W2      = 2 * W;
  localparam logic [W-1:0] CNT_MAX = '1;

  logic [W-1:0]  cnt0, cnt1, capv0, capv1;
  logic [W2-1:0] val0, cmpv0, meas_val;
  logic run0, run1, meas0, rise, fall, hit0, hit1;
  logic clr0, clr1, inc1, wrap0, edge_clr, edge_cap, shadow0, ld0, ld1;

  dt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(gate_in), .rise(rise), .fall(fall)
  );

  always_comb begin
    run0     = t0_mode inside {MD_COUNT, MD_FREQ, MD_PWM, MD_PERIOD, MD_PULSE};
    run1     = !cascade && (t1_mode inside {MD_COUNT, MD_FREQ, MD_PWM});
    meas0    = t0_mode inside {MD_PERIOD, MD_PULSE};
    val0     = cascade ? {cnt1, cnt0}   : {{W{1'b0}}, cnt0};
    cmpv0    = cascade ? {t1_cmp, t0_cmp} : {{W{1'b0}}, t0_cmp};
    meas_val = val0 + 1'b1;
    edge_clr = meas0 && rise;
    edge_cap = ((t0_mode == MD_PERIOD) && rise) || ((t0_mode == MD_PULSE) && fall);
    clr0     = ((t0_mode == MD_FREQ) && hit0) || edge_clr;
    wrap0    = run0 && (cnt0 == CNT_MAX);
    clr1     = cascade ? clr0 : ((t1_mode == MD_FREQ) && hit1);
    inc1     = cascade ? wrap0 : run1;
    shadow0  = !meas0 && (t0_rd || (cascade && t1_rd));
    ld0      = edge_cap || shadow0;
    ld1      = cascade ? (edge_cap || shadow0) : t1_rd;
    capv0    = edge_cap ? meas_val[W-1:0] : cnt0;
    capv1    = (cascade && edge_cap) ? meas_val[W2-1:W] : cnt1;
  end

  dt_slice #(.W(W)) u_slice0 (
    .clk(clk), .rst(rst), .inc(run0), .clr(clr0),
    .cap_ld(ld0), .cap_val(capv0), .cnt(cnt0), .cap(t0_cap)
  );

  dt_slice #(.W(W)) u_slice1 (
    .clk(clk), .rst(rst), .inc(inc1), .clr(clr1),
    .cap_ld(ld1), .cap_val(capv1), .cnt(cnt1), .cap(t1_cap)
  );

  dt_wave #(.VW(W2)) u_wave0 (
    .clk(clk), .rst(rst), .en(run0), .mode(t0_mode), .val(val0), .cmp(cmpv0),
    .hit(hit0), .match_q(t0_match), .wave_q(t0_wave)
  );

  dt_wave #(.VW(W)) u_wave1 (
    .clk(clk), .rst(rst), .en(run1), .mode(t1_mode), .val(cnt1), .cmp(t1_cmp),
    .hit(hit1), .match_q(t1_match), .wave_q(t1_wave)
  );

  assign t0_count = cnt0;
  assign t1_count = cnt1;
endmodule

// File: rtl/dt_timer_chk.sv
module dt_timer_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         cascade,
  input logic [2:0]   t0_mode,
  input logic [2:0]   t1_mode,
  input logic [W-1:0] t1_cmp,
  input logic         t1_rd,
  input logic [W-1:0] t0_count,
  input logic [W-1:0] t1_count,
  input logic [W-1:0] t1_cap,
  input logic         t1_match,
  input logic         t1_wave
);
  localparam logic [W-1:0] MAXV = '1;
  localparam logic [W-1:0] ONE  = W'(1);

  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (t0_mode == 3'd0) |=> (t0_count == $past(t0_count))); // R2
  AST_T1_STEP: assert property (@(posedge clk) disable iff (rst)
    (!cascade && t1_mode == 3'd1) |=> (t1_count == $past(t1_count) + ONE)); // R3
  AST_CASC_HOLD: assert property (@(posedge clk) disable iff (rst)
    (cascade && t0_mode == 3'd1 && t0_count != MAXV) |=> $stable(t1_count)); // R4
  AST_CASC_QUIET: assert property (@(posedge clk) disable iff (rst)
    cascade |=> (!t1_wave && !t1_match)); // R4
  AST_MATCH_FLAG: assert property (@(posedge clk) disable iff (rst)
    (!cascade && t1_mode == 3'd1 && t1_count == t1_cmp) |=> t1_match); // R5
  AST_FREQ_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (!cascade && t1_mode == 3'd2 && t1_count == t1_cmp) |=> (t1_count == '0)); // R6
  AST_PWM_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (!cascade && t1_mode == 3'd3) |=> (t1_wave == ($past(t1_count) < $past(t1_cmp)))); // R7
  AST_SHADOW_LOAD: assert property (@(posedge clk) disable iff (rst)
    (!cascade && t1_rd) |=> (t1_cap == $past(t1_count))); // R8
  AST_T1_MEAS_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!cascade && (t1_mode == 3'd4 || t1_mode == 3'd5)) |=> $stable(t1_count)); // R12
endmodule

bind dt_timer dt_timer_chk #(.W(W)) u_chk (.*);

// File: tb/tb_dt_timer.sv
module tb_dt_timer;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst, cascade, t0_rd, t1_rd, gate_in;
  logic [2:0] t0_mode, t1_mode;
  logic [7:0] t0_cmp, t1_cmp;
  logic [7:0] t0_count, t1_count, t0_cap, t1_cap;
  logic       t0_match, t1_match, t0_wave, t1_wave;
  int checks = 0;
  int errs   = 0;

  dt_timer #(.W(8)) dut (
    .clk(clk), .rst(rst), .cascade(cascade), .t0_mode(t0_mode), .t1_mode(t1_mode),
    .t0_cmp(t0_cmp), .t1_cmp(t1_cmp), .t0_rd(t0_rd), .t1_rd(t1_rd), .gate_in(gate_in),
    .t0_count(t0_count), .t1_count(t1_count), .t0_cap(t0_cap), .t1_cap(t1_cap),
    .t0_match(t0_match), .t1_match(t1_match), .t0_wave(t0_wave), .t1_wave(t1_wave)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; cascade = 1'b0; t0_mode = 3'd0; t1_mode = 3'd0;
    t0_cmp = 8'd0; t1_cmp = 8'd0; t0_rd = 1'b0; t1_rd = 1'b0; gate_in = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errs++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end

  initial begin
    int fcmp[5]  = '{0, 1, 2, 5, 255};
    int pcmp[5]  = '{0, 1, 3, 128, 255};
    int pers[4]  = '{3, 7, 20, 100};
    int widths[5] = '{1, 2, 5, 50, 200};

    // R1 reset state
    do_reset();
    chk("R1 t0_count", t0_count, 0); chk("R1 t1_count", t1_count, 0);
    chk("R1 t0_cap", t0_cap, 0);     chk("R1 t1_cap", t1_cap, 0);
    chk("R1 t0_match", t0_match, 0); chk("R1 t1_match", t1_match, 0);
    chk("R1 t0_wave", t0_wave, 0);   chk("R1 t1_wave", t1_wave, 0);

    // R3 free counting with wrap, then R2 / R12 hold
    t0_mode = 3'd1; t1_mode = 3'd1;
    for (int i = 1; i <= 300; i++) begin
      @(negedge clk);
      chk("R3 t0_count", t0_count, i % 256);
      chk("R3 t1_count", t1_count, i % 256);
    end
    t0_mode = 3'd0; t1_mode = 3'd4;
    wait_cyc(5);
    chk("R2 t0 halted", t0_count, 44);
    chk("R12 t1 mode4 halted", t1_count, 44);
    t1_mode = 3'd5;
    wait_cyc(5);
    chk("R12 t1 mode5 halted", t1_count, 44);

    // R4 / R5 cascade, 16-bit compare at 300, then R8 joint shadow
    do_reset();
    cascade = 1'b1; t0_mode = 3'd1; t1_mode = 3'd3;
    t0_cmp = 8'h2C; t1_cmp = 8'h01;
    for (int i = 1; i <= 700; i++) begin
      @(negedge clk);
      chk("R4 joined count", {t1_count, t0_count}, i);
      chk("R5 joined match", t0_match, (i == 301) ? 1 : 0);
      chk("R4 t1_wave quiet", t1_wave, 0);
      chk("R4 t1_match quiet", t1_match, 0);
    end
    t0_rd = 1'b1;
    @(negedge clk);
    t0_rd = 1'b0;
    chk("R8 joined cap lo", t0_cap, 8'hBC);
    chk("R8 joined cap hi", t1_cap, 8'h02);
    wait_cyc(4);
    chk("R8 joined cap frozen", {t1_cap, t0_cap}, 700);

    // R6 / R5 frequency sweep on both timers
    foreach (fcmp[k]) begin
      int len;
      do_reset();
      len = fcmp[k] + 1;
      t0_mode = 3'd2; t1_mode = 3'd2; t0_cmp = fcmp[k]; t1_cmp = fcmp[k];
      for (int i = 1; i <= 3 * len + 2; i++) begin
        @(negedge clk);
        chk("R6 t0_count", t0_count, i % len);
        chk("R6 t0_wave", t0_wave, (i / len) % 2);
        chk("R6 t1_count", t1_count, i % len);
        chk("R6 t1_wave", t1_wave, (i / len) % 2);
        chk("R5 t0_match", t0_match, (((i - 1) % len) == fcmp[k]) ? 1 : 0);
        chk("R5 t1_match", t1_match, (((i - 1) % len) == fcmp[k]) ? 1 : 0);
      end
    end

    // R7 PWM sweep
    foreach (pcmp[k]) begin
      do_reset();
      t0_mode = 3'd3; t1_mode = 3'd3; t0_cmp = pcmp[k]; t1_cmp = pcmp[k];
      for (int i = 1; i <= 260; i++) begin
        @(negedge clk);
        chk("R7 t1_count", t1_count, i % 256);
        chk("R7 t0_wave", t0_wave, (((i - 1) % 256) < pcmp[k]) ? 1 : 0);
        chk("R7 t1_wave", t1_wave, (((i - 1) % 256) < pcmp[k]) ? 1 : 0);
      end
    end

    // R8 single-timer shadow
    do_reset();
    t1_mode = 3'd1;
    wait_cyc(10);
    t1_rd = 1'b1;
    @(negedge clk);
    t1_rd = 1'b0;
    chk("R8 t1_cap load", t1_cap, 10);
    wait_cyc(5);
    chk("R8 t1_cap frozen", t1_cap, 10);
    chk("R8 t1 still counting", t1_count, 16);

    // R9 reads ignored in measurement modes
    do_reset();
    t0_mode = 3'd4;
    wait_cyc(20);
    t0_rd = 1'b1; t1_rd = 1'b1;
    @(negedge clk);
    t0_rd = 1'b0; t1_rd = 1'b0;
    @(negedge clk);
    chk("R9 t0_cap untouched", t0_cap, 0);
    t0_mode = 3'd5;
    t0_rd = 1'b1;
    @(negedge clk);
    t0_rd = 1'b0;
    @(negedge clk);
    chk("R9 t0_cap untouched pw", t0_cap, 0);

    // R10 period sweep
    foreach (pers[k]) begin
      do_reset();
      t0_mode = 3'd4;
      gate_in = 1'b1; wait_cyc(2); gate_in = 1'b0; wait_cyc(pers[k] - 2);
      gate_in = 1'b1; wait_cyc(2); gate_in = 1'b0; wait_cyc(6);
      chk("R10 period", t0_cap, pers[k]);
    end
    do_reset();
    cascade = 1'b1; t0_mode = 3'd4;
    gate_in = 1'b1; wait_cyc(2); gate_in = 1'b0; wait_cyc(698);
    gate_in = 1'b1; wait_cyc(2); gate_in = 1'b0; wait_cyc(6);
    chk("R10 joined period", {t1_cap, t0_cap}, 700);

    // R11 high-time sweep
    foreach (widths[k]) begin
      do_reset();
      t0_mode = 3'd5;
      wait_cyc(3);
      gate_in = 1'b1; wait_cyc(widths[k]); gate_in = 1'b0; wait_cyc(6);
      chk("R11 high time", t0_cap, widths[k]);
      chk("R11 restart on rise", t0_count, widths[k] + 3);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end
endmodule